// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 14-bit virtual address into a physical address. It walks a two-level page table kept in a word-addressed memory, where every table entry fills one 32-bit word. The address splits into a 4-bit directory index, a 4-bit sub-table index and a 6-bit byte offset inside a 64-byte page. The walker first reads the directory word at `root_base + directory index`. If that entry is present, its frame field gives the word address of a 16-entry sub-table, and the walker reads the leaf word at `frame + sub-table index`. A directory entry whose present bit is clear stands for a pruned sub-table, so the walk stops there.

After the leaf read the walker checks the present, writable and user bits. On success it returns the physical address. It also writes the leaf back with the accessed bit set, and with the dirty bit set as well when the access is a write. Entry layout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bits 31:12 frame number.

Requests and responses use valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. A producer holding valid high must keep its payload steady until that edge. The consumer may hold ready low for as long as it likes. The memory port carries one access at a time. A read or write request is offered with `mem_req_valid` and completes when `mem_req_ready` is high. A read returns its word on `mem_rsp_valid`, one or more cycles after the request is accepted. A write completes at acceptance and gets no response.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. `req_ready` is high only while no walk is in progress, so a new request is accepted only when the walker is idle.
- R2: The directory read goes to word `root + va[13:10]`. The leaf read goes to word `dir_entry[12 +: MADDR_W] + va[9:6]`, and this sum wraps modulo 2^MADDR_W.
- R3: A directory entry with bit 0 clear ends the walk with code 1 and `rsp_paddr` = 0, after exactly one memory read.
- R4: A leaf entry with bit 0 clear gives code 2.
- R5: A user access (`req_user`=1) to a present leaf with bit 2 clear gives code 4. This check takes priority over the write check.
- R6: A write to a present, accessible leaf with bit 1 clear gives code 3.
- R7: A walk with no fault gives code 0 and `rsp_paddr = {leaf[12 +: PA_W-6], va[5:0]}`.
- R8: A walk with no fault writes the leaf back exactly once, to the leaf address. The written word has bit 5 set, has bit 6 set when the access is a write, and leaves every other bit unchanged.
- R9: The write-back is skipped when the leaf already has every bit it would set (bit 5 for a read, bits 5 and 6 for a write).
- R10: A walk that ends in any fault writes nothing to memory.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and unchanged. While `mem_req_valid` is high and `mem_req_ready` is low, the memory request stays valid and unchanged.
- R12: The root pointer is captured when a request is accepted. A change on `root_base` during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| root_base | input | MADDR_W | Word address of the directory table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Memory access offered |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | MADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data (updated leaf entry) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |
| rsp_code | output | 3 | 0 ok, 1 directory absent, 2 leaf absent, 3 write to read-only, 4 user to supervisor page |

## Verification
The bench builds the walker with MADDR_W = 10 and PA_W = 16. With these values the whole table memory is a 1024-word array inside the bench, so a sub-table placed near the top of that space makes the leaf address wrap, and the scoreboard can check every table word the walk touches. The 10-bit frame field of the physical address also lets the bench compare the translated address in full. Periodic stalls on memory acceptance and on the response consumer exercise the hold rules in both handshakes.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_DIR,
    ST_READ_LEAF,
    ST_UPDATE,
    ST_DONE
  } walk_state_e;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_DIR_ABSENT  = 3'd1,
    FLT_LEAF_ABSENT = 3'd2,
    FLT_WRITE_PROT  = 3'd3,
    FLT_PRIV        = 3'd4
  } fault_e;

  localparam int PTE_W     = 32;
  localparam int PTE_P     = 0;
  localparam int PTE_W_BIT = 1;
  localparam int PTE_U     = 2;
  localparam int PTE_A     = 5;
  localparam int PTE_D     = 6;
  localparam int FRAME_LSB = 12;

endpackage

// File: rtl/pt_walk_index.sv
module pt_walk_index
  import pt_walk_pkg::*;
#(
  parameter int VA_W    = 14,
  parameter int OFF_W   = 6,
  parameter int DIR_W   = 4,
  parameter int MADDR_W = 12
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [MADDR_W-1:0] root,
  input  logic [MADDR_W-1:0] dir_frame,
  output logic [MADDR_W-1:0] dir_addr,
  output logic [MADDR_W-1:0] leaf_addr
);
  localparam int LEAF_W = VA_W - OFF_W - DIR_W;

  logic [DIR_W-1:0]  dir_idx;
  logic [LEAF_W-1:0] leaf_idx;

  assign dir_idx  = vaddr[VA_W-1 -: DIR_W];
  assign leaf_idx = vaddr[OFF_W +: LEAF_W];

  // both sums wrap modulo the memory word space
  assign dir_addr  = root + MADDR_W'(dir_idx);
  assign leaf_addr = dir_frame + MADDR_W'(leaf_idx);
endmodule

// File: rtl/pt_walk_perm.sv
module pt_walk_perm
  import pt_walk_pkg::*;
#(
  parameter int OFF_W = 6,
  parameter int PA_W  = 20
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  input  logic [OFF_W-1:0] offset,
  output logic [2:0]       code,
  output logic             need_wb,
  output logic [PTE_W-1:0] wb_entry,
  output logic [PA_W-1:0]  paddr
);
  localparam int FRAME_W = PA_W - OFF_W;

  // fault priority: absent, then privilege, then write protection
  always_comb begin
    code = FLT_NONE;
    if (!entry[PTE_P])                    code = FLT_LEAF_ABSENT;
    else if (is_user && !entry[PTE_U])    code = FLT_PRIV;
    else if (is_write && !entry[PTE_W_BIT]) code = FLT_WRITE_PROT;
  end

  always_comb begin
    wb_entry        = entry;
    wb_entry[PTE_A] = 1'b1;
    if (is_write) wb_entry[PTE_D] = 1'b1;
  end

  assign need_wb = (wb_entry != entry);
  assign paddr   = {entry[FRAME_LSB +: FRAME_W], offset};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W    = 14,
  parameter int OFF_W   = 6,
  parameter int DIR_W   = 4,
  parameter int MADDR_W = 12,
  parameter int PA_W    = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MADDR_W-1:0] root_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [2:0]         rsp_code
);
  walk_state_e        state_q;
  logic               issued_q;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic               us_q;
  logic [MADDR_W-1:0] root_q;
  logic [MADDR_W-1:0] leaf_addr_q;
  logic [31:0]        wdata_q;
  logic [PA_W-1:0]    paddr_q;
  logic [2:0]         code_q;

  logic [MADDR_W-1:0] dir_addr;
  logic [MADDR_W-1:0] leaf_addr;
  logic [2:0]         perm_code;
  logic               perm_wb;
  logic [31:0]        perm_entry;
  logic [PA_W-1:0]    perm_paddr;
  logic               rd_back;

  pt_walk_index #(
    .VA_W(VA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .MADDR_W(MADDR_W)
  ) u_index (
    .vaddr    (va_q),
    .root     (root_q),
    .dir_frame(mem_rdata[FRAME_LSB +: MADDR_W]),
    .dir_addr (dir_addr),
    .leaf_addr(leaf_addr)
  );

  pt_walk_perm #(.OFF_W(OFF_W), .PA_W(PA_W)) u_perm (
    .entry   (mem_rdata),
    .is_write(wr_q),
    .is_user (us_q),
    .offset  (va_q[OFF_W-1:0]),
    .code    (perm_code),
    .need_wb (perm_wb),
    .wb_entry(perm_entry),
    .paddr   (perm_paddr)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_code      = code_q;
  assign mem_req_valid = !issued_q && (state_q == ST_READ_DIR ||
                                       state_q == ST_READ_LEAF ||
                                       state_q == ST_UPDATE);
  assign mem_we        = (state_q == ST_UPDATE);
  assign mem_addr      = (state_q == ST_READ_DIR) ? dir_addr : leaf_addr_q;
  assign mem_wdata     = wdata_q;
  assign rd_back       = issued_q && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      issued_q    <= 1'b0;
      va_q        <= '0;
      wr_q        <= 1'b0;
      us_q        <= 1'b0;
      root_q      <= '0;
      leaf_addr_q <= '0;
      wdata_q     <= '0;
      paddr_q     <= '0;
      code_q      <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            us_q     <= req_user;
            root_q   <= root_base;
            issued_q <= 1'b0;
            state_q  <= ST_READ_DIR;
          end
        end
        ST_READ_DIR: begin
          if (rd_back) begin
            if (!mem_rdata[PTE_P]) begin
              code_q  <= FLT_DIR_ABSENT;
              paddr_q <= '0;
              state_q <= ST_DONE;
            end else begin
              leaf_addr_q <= leaf_addr;
              issued_q    <= 1'b0;
              state_q     <= ST_READ_LEAF;
            end
          end
        end
        ST_READ_LEAF: begin
          if (rd_back) begin
            code_q  <= perm_code;
            paddr_q <= (perm_code == FLT_NONE) ? perm_paddr : '0;
            if (perm_code == FLT_NONE && perm_wb) begin
              wdata_q  <= perm_entry;
              issued_q <= 1'b0;
              state_q  <= ST_UPDATE;
            end else begin
              state_q <= ST_DONE;
            end
          end
        end
        ST_UPDATE: begin
          if (mem_req_valid && mem_req_ready) state_q <= ST_DONE;
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  one_walk_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !rsp_valid && !mem_req_valid);

  // R3
  dir_absent_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_READ_DIR && rd_back && !mem_rdata[PTE_P]
      |=> rsp_valid && rsp_code == 3'd1 && rsp_paddr == '0);

  // R8
  wb_sets_a_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_we |-> mem_wdata[PTE_A] && rsp_code == 3'd0);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_code));

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready
      |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int MW = 10;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] root_base = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [13:0]   req_vaddr = '0;
  logic          req_write = 1'b0;
  logic          req_user = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic          mem_we;
  logic [MW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rdata;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [PW-1:0] rsp_paddr;
  logic [2:0]    rsp_code;

  always #2.5 clk = ~clk;

  pt_walker #(.MADDR_W(MW), .PA_W(PW)) uut (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_code(rsp_code)
  );

  typedef struct {
    logic [2:0]    code;
    logic [PW-1:0] pa;
    int            nreads;
    logic [MW-1:0] ra0, ra1;
    bit            wb;
    logic [MW-1:0] waddr;
    logic [31:0]   wdata;
    string         tag;
  } exp_t;

  logic [31:0]   mem [0:1023];
  exp_t          sb_q[$];
  logic [MW-1:0] rd_log[$];
  int            wr_cnt = 0;
  int            wr_base = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] mkva(input int d, input int l, input int o);
    return {d[3:0], l[3:0], o[5:0]};
  endfunction

  function automatic exp_t predict(input logic [13:0] va, input bit wr, input bit us,
                                   input logic [MW-1:0] root, input string tag);
    exp_t e;
    logic [31:0] d, l, n;
    logic [MW-1:0] da, la;
    e.tag = tag; e.wb = 0; e.pa = '0; e.nreads = 1; e.ra1 = '0;
    e.waddr = '0; e.wdata = '0; e.code = 3'd0;
    da = root + MW'(va[13:10]);
    e.ra0 = da;
    d = mem[da];
    if (!d[0]) begin
      e.code = 3'd1;
      return e;
    end
    la = d[12 +: MW] + MW'(va[9:6]);
    e.nreads = 2;
    e.ra1 = la;
    l = mem[la];
    if (!l[0])               e.code = 3'd2;
    else if (us && !l[2])    e.code = 3'd4;
    else if (wr && !l[1])    e.code = 3'd3;
    else begin
      e.pa = {l[12 +: PW-6], va[5:0]};
      n = l | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (n != l) begin
        e.wb = 1; e.waddr = la; e.wdata = n;
      end
    end
    return e;
  endfunction

  // memory model: fixed stall pattern, read data one cycle after acceptance
  initial begin : mem_model
    bit            pend = 0;
    logic [MW-1:0] pend_addr = '0;
    bit            mhold = 0;
    logic [MW-1:0] h_addr = '0;
    logic          h_we = 0;
    logic [31:0]   h_wd = '0;
    int            mcnt = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rdata     = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rdata     = mem[pend_addr];
        pend          = 0;
      end
      if (mhold)
        check(mem_req_valid && mem_addr == h_addr && mem_we == h_we && mem_wdata == h_wd,
              "R11", "memory request held", {21'd0, mem_req_valid, mem_addr}, {21'd1, h_addr});
      mem_req_ready = (mcnt % 3) != 2;
      mcnt++;
      mhold = 0;
      if (!rst && mem_req_valid) begin
        if (mem_req_ready) begin
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
          end else begin
            pend      = 1;
            pend_addr = mem_addr;
            rd_log.push_back(mem_addr);
          end
        end else begin
          mhold = 1; h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
        end
      end
    end
  end

  // monitor: pops the scoreboard when a response is taken
  initial begin : monitor
    int            rcnt = 0;
    bit            hold = 0;
    logic [PW-1:0] h_pa = '0;
    logic [2:0]    h_code = '0;
    exp_t          e;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (hold)
        check(rsp_valid && rsp_paddr == h_pa && rsp_code == h_code, "R11",
              "response held", {13'd0, rsp_code, rsp_paddr}, {13'd0, h_code, h_pa});
      rsp_ready = (rcnt % 4) != 2;
      rcnt++;
      hold = rsp_valid && !rsp_ready;
      h_pa = rsp_paddr;
      h_code = rsp_code;
      if (!rst && rsp_valid && rsp_ready) begin
        if (sb_q.size() == 0) begin
          check(0, "R1", "unexpected response", 32'd1, 32'd0);
        end else begin
          e = sb_q[0];
          check(rsp_code == e.code, e.tag, "fault code", 32'(rsp_code), 32'(e.code));
          check(rsp_paddr == e.pa, e.tag, "physical address", 32'(rsp_paddr), 32'(e.pa));
          check(rd_log.size() == e.nreads, "R2", "read count",
                32'(rd_log.size()), 32'(e.nreads));
          if (rd_log.size() >= 1)
            check(rd_log[0] == e.ra0, "R2", "directory address", 32'(rd_log[0]), 32'(e.ra0));
          if (rd_log.size() >= 2 && e.nreads == 2)
            check(rd_log[1] == e.ra1, "R2", "leaf address", 32'(rd_log[1]), 32'(e.ra1));
          check((wr_cnt - wr_base) == (e.wb ? 1 : 0), e.code != 0 ? "R10" : (e.wb ? "R8" : "R9"),
                "write count", 32'(wr_cnt - wr_base), e.wb ? 32'd1 : 32'd0);
          if (e.wb)
            check(mem[e.waddr] == e.wdata, "R8", "written entry", mem[e.waddr], e.wdata);
          void'(sb_q.pop_front());
        end
      end
    end
  end

  task automatic walk(input logic [13:0] va, input bit wr, input bit us,
                      input string tag, input bit swap_root);
    exp_t e;
    logic [MW-1:0] keep;
    wait (sb_q.size() == 0);
    @(negedge clk);
    keep = root_base;
    e = predict(va, wr, us, root_base, tag);
    rd_log.delete();
    wr_base = wr_cnt;
    sb_q.push_back(e);
    req_vaddr = va; req_write = wr; req_user = us; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (swap_root) begin
      root_base = keep ^ 10'h020;
      wait (sb_q.size() == 0);
      @(negedge clk);
      root_base = keep;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // directory A at 0x010, directory B at 0x030
    mem[10'h011] = (32'h100 << 12) | 32'h1;
    mem[10'h01F] = (32'h3F8 << 12) | 32'h1;
    mem[10'h031] = (32'h200 << 12) | 32'h1;
    mem[10'h101] = (32'h02A << 12) | 32'h01;
    mem[10'h102] = (32'h155 << 12) | 32'h07;
    mem[10'h103] = (32'h3C3 << 12) | 32'h25;
    mem[10'h104] = (32'h011 << 12) | 32'h227;
    mem[10'h001] = (32'h3FF << 12) | 32'h05;
    mem[10'h202] = (32'h099 << 12) | 32'h07;
    root_base = 10'h010;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset req_ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 32'(mem_req_valid), 32'd0);

    walk(mkva(0, 0, 5),     0, 0, "R3", 0);
    walk(mkva(1, 0, 0),     0, 0, "R4", 0);
    walk(mkva(1, 1, 6'h3F), 1, 1, "R5", 0);
    walk(mkva(1, 1, 6'h10), 1, 0, "R6", 0);
    walk(mkva(1, 1, 6'h22), 0, 0, "R7", 0);
    walk(mkva(1, 2, 6'h01), 0, 1, "R8", 0);
    walk(mkva(1, 2, 6'h02), 0, 1, "R9", 0);
    walk(mkva(1, 2, 6'h3E), 1, 1, "R8", 0);
    walk(mkva(1, 2, 6'h3D), 1, 1, "R9", 0);
    walk(mkva(1, 3, 6'h07), 0, 1, "R9", 0);
    walk(mkva(1, 3, 6'h08), 1, 1, "R6", 0);
    walk(mkva(1, 4, 6'h2C), 1, 0, "R8", 0);
    walk(mkva(15, 9, 6'h11), 0, 1, "R2", 0);
    walk(mkva(2, 3, 6'h00), 0, 0, "R3", 0);
    walk(mkva(1, 1, 6'h05), 1, 1, "R12", 1);
    root_base = 10'h030;
    walk(mkva(1, 2, 6'h0F), 1, 0, "R7", 0);
    wait (sb_q.size() == 0);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule